// File: doc/BRIEF.md
# Single-error correcting codeword decoder

This block pairs an encoder and a decoder for a short five-bit code that protects three data bits with two odd-parity checks. The encoder appends the two check bits to the three data bits. The decoder takes a received word that may have at most one flipped bit, in either direction, and rebuilds the data. It also reports two flags: one says the word was a valid codeword as received, the other says the recovered data is the only possible answer.

The code has a minimum distance of two, so some single-bit errors leave two or more codewords at the same distance from the received word. The decoder compares the received word with every codeword by Hamming distance. It keeps the nearest candidates and outputs the data bits on which all of them agree. Any bit the candidates disagree on is driven to 0. The decoder results pass through an output register with a clock enable. The encoder output is combinational.

Top module: `scd_codec`

## Requirements
- R1: The encoder output `enc_word_o` is {x, y, z, v, w}, with bit 4 the most significant. Here {x, y, z} = `enc_data_i[2:0]`, v = NOT(x XOR z) and w = NOT(y XOR z). Check v makes x, z, v hold an odd number of ones, and check w does the same for y, z, w.
- R2: The eight codewords for data 0 to 7 are, in order: 00011, 00100, 01010, 01101, 10001, 10110, 11000, 11111.
- R3: A received word that equals a codeword decodes to that codeword's data, with exact = 1 and unique = 1.
- R4: A word that is not a codeword and has exactly one codeword at distance one decodes to that codeword's data, with exact = 0 and unique = 1. For example, 00111 gives 000 and 00000 gives 001.
- R5: A word with two or more codewords at distance one gives exact = 0 and unique = 0. Each data bit on which all candidates agree takes the agreed value, and each other bit is 0. For example, 00010 gives 000.
- R6: The decoder outputs take the result for `rx_word_i` at a rising clock edge where `en` = 1. At an edge where `en` = 0 they hold their value.
- R7: While `rst_n` is low, `dec_data_o`, `exact_o` and `unique_o` are 0, with no clock edge needed. Reset is released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the decoder output register |
| enc_data_i | input | 3 | Data bits to encode, {x, y, z} |
| enc_word_o | output | 5 | Encoded word, {x, y, z, v, w} |
| rx_word_i | input | 5 | Received word to decode |
| dec_data_o | output | 3 | Recovered data bits, registered |
| exact_o | output | 1 | The received word was a codeword |
| unique_o | output | 1 | The recovered data is the only possible answer |

## Verification
The bench encodes all eight data values. For each codeword it applies the word itself and all five single-bit flips, so every received pattern reachable by one error is covered, both unique and ambiguous.

Each case has its own failure to catch:
- A decoder that picks the first candidate found would put a nonzero value on an undetermined bit of an ambiguous word.
- A decoder that counts all distance-one neighbours without first preferring an exact match would report unique = 0 for a valid word.
- A check bit built with even instead of odd parity would invert v or w.

Directed tests cover an asynchronous reset applied mid-run, and a word presented with the enable low that must leave the registered result unchanged.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int DATA_W = 3;
  localparam int CHK_W  = DATA_W - 1;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int NUM_CW = 1 << DATA_W;

  // check bit j pairs data bit (DATA_W-1-j) with the last data bit, odd parity
  function automatic logic [WORD_W-1:0] scd_encode(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    for (int j = 0; j < CHK_W; j++) begin
      c[CHK_W-1-j] = ~(d[DATA_W-1-j] ^ d[0]);
    end
    return {d, c};
  endfunction
endpackage

// File: rtl/scd_encoder.sv
module scd_encoder
  import scd_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = scd_encode(data_i);
  end
endmodule

// File: rtl/scd_decoder.sv
module scd_decoder
  import scd_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              exact_o,
  output logic              unique_o
);
  logic [NUM_CW-1:0] at_zero;
  logic [NUM_CW-1:0] at_one;
  logic [NUM_CW-1:0] cand;

  // one distance comparator per codeword
  for (genvar k = 0; k < NUM_CW; k++) begin : g_cw
    localparam logic [DATA_W-1:0] KVAL = DATA_W'(k);
    logic [WORD_W-1:0] diff;
    always_comb begin
      diff       = word_i ^ scd_encode(KVAL);
      at_zero[k] = ($countones(diff) == 0);
      at_one[k]  = ($countones(diff) == 1);
    end
  end

  logic [DATA_W-1:0] agree;
  always_comb begin
    cand  = (|at_zero) ? at_zero : at_one;
    agree = '1;
    for (int k = 0; k < NUM_CW; k++) begin
      if (cand[k]) agree = agree & DATA_W'(k);
    end
    data_o   = (|cand) ? agree : '0;
    exact_o  = |at_zero;
    unique_o = ($countones(cand) == 1);
  end
endmodule

// File: rtl/scd_outreg.sv
module scd_outreg #(
  parameter int W   = 5,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG) begin : g_reg
    logic [W-1:0] q_next;
    always_comb begin
      q_next = en ? d : q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_next;
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q));
  end else begin : g_comb
    assign q = d;
  end
endmodule

// File: rtl/scd_codec.sv
module scd_codec
  import scd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [WORD_W-1:0] enc_word_o,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              exact_o,
  output logic              unique_o
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  scd_encoder u_enc (.data_i(enc_data_i), .word_o(enc_word_o));

  logic [DATA_W-1:0] dec_data_c;
  logic              dec_exact_c;
  logic              dec_unique_c;

  scd_decoder u_dec (
    .word_i  (rx_word_i),
    .data_o  (dec_data_c),
    .exact_o (dec_exact_c),
    .unique_o(dec_unique_c)
  );

  logic [DATA_W+1:0] res_q;

  scd_outreg #(.W(DATA_W + 2), .REG(REG_OUT)) u_oreg (
    .clk  (clk),
    .rst_n(rst_int_n),
    .en   (en),
    .d    ({dec_data_c, dec_exact_c, dec_unique_c}),
    .q    (res_q)
  );

  assign dec_data_o = res_q[DATA_W+1:2];
  assign exact_o    = res_q[1] & rst_n;
  assign unique_o   = res_q[0] & rst_n;

  assert_exact_reencodes_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    dec_exact_c |-> (scd_encode(dec_data_c) == rx_word_i));

  assert_unique_near_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dec_unique_c && !dec_exact_c) |-> ($countones(scd_encode(dec_data_c) ^ rx_word_i) == 1));

  assert_exact_unique_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    exact_o |-> unique_o);
endmodule

// File: tb/scd_codec_bench.sv
`timescale 1ns/1ps
module scd_codec_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [2:0] enc_data_i;
  logic [4:0] enc_word_o;
  logic [4:0] rx_word_i;
  logic [2:0] dec_data_o;
  logic       exact_o;
  logic       unique_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scd_codec u_scd_codec (
    .clk(clk), .rst_n(rst_n), .en(en),
    .enc_data_i(enc_data_i), .enc_word_o(enc_word_o),
    .rx_word_i(rx_word_i), .dec_data_o(dec_data_o),
    .exact_o(exact_o), .unique_o(unique_o)
  );

  // {data, codeword}, indexed by data value (R2)
  localparam logic [7:0] CW_TAB [8] = '{
    {3'd0, 5'b00011}, {3'd1, 5'b00100}, {3'd2, 5'b01010}, {3'd3, 5'b01101},
    {3'd4, 5'b10001}, {3'd5, 5'b10110}, {3'd6, 5'b11000}, {3'd7, 5'b11111}
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // reference: nearest codewords from the table, AND of their data bits
  task automatic ref_decode(input logic [4:0] r, output logic [2:0] d,
                            output logic f, output logic g);
    int near_n = 0;
    logic [2:0] acc = 3'b111;
    f = 1'b0;
    d = 3'b000;
    for (int i = 0; i < 8; i++) begin
      if (CW_TAB[i][4:0] == r) begin
        f = 1'b1;
        d = CW_TAB[i][7:5];
      end
    end
    if (f) begin
      g = 1'b1;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if ($countones(CW_TAB[i][4:0] ^ r) == 1) begin
          near_n++;
          acc &= CW_TAB[i][7:5];
        end
      end
      g = (near_n == 1);
      d = (near_n > 0) ? acc : 3'b000;
    end
  endtask

  task automatic decode_one(input logic [4:0] r, output logic [4:0] got);
    @(negedge clk);
    rx_word_i = r;
    en = 1'b1;
    @(negedge clk);
    got = {dec_data_o, exact_o, unique_o};
  endtask

  initial begin
    logic [4:0] got;
    logic [2:0] ed;
    logic ef, eg;
    rst_n = 1'b0;
    en = 1'b0;
    enc_data_i = '0;
    rx_word_i = 5'b11111;
    #5;
    check("R7 reset state", {dec_data_o, exact_o, unique_o}, 5'b0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: encoder, then no-error and every single-flip variant
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      enc_data_i = CW_TAB[i][7:5];
      #1;
      check("R1/R2 encode", enc_word_o, CW_TAB[i][4:0]);
      for (int fb = -1; fb < 5; fb++) begin
        logic [4:0] r;
        r = CW_TAB[i][4:0];
        if (fb >= 0) r[fb] = ~r[fb];
        ref_decode(r, ed, ef, eg);
        decode_one(r, got);
        if (ef)      check("R3 exact", got, {ed, ef, eg});
        else if (eg) check("R4 unique", got, {ed, ef, eg});
        else         check("R5 ambiguous", got, {ed, ef, eg});
      end
    end

    // directed corner cases
    decode_one(5'b00111, got);
    check("R4 00111", got, {3'b000, 1'b0, 1'b1});
    decode_one(5'b00000, got);
    check("R4 00000", got, {3'b001, 1'b0, 1'b1});
    decode_one(5'b00010, got);
    check("R5 00010", got, {3'b000, 1'b0, 1'b0});
    decode_one(5'b11111, got);
    check("R3 11111", got, {3'b111, 1'b1, 1'b1});

    // enable low: new word must not reach the outputs
    @(negedge clk);
    en = 1'b0;
    rx_word_i = 5'b00000;
    repeat (2) @(negedge clk);
    check("R6 hold", {dec_data_o, exact_o, unique_o}, {3'b111, 1'b1, 1'b1});
    en = 1'b1;
    @(negedge clk);
    check("R6 update", {dec_data_o, exact_o, unique_o}, {3'b001, 1'b0, 1'b1});

    // asynchronous reset mid-run, checked before any edge
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #2;
    check("R7 async reset", {dec_data_o, exact_o, unique_o}, 5'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule